// File: doc/BRIEF.md
# Folded Synchronous Memory Array

This block is a synchronous behavioural memory of 2^N words, each 2^M bits wide, held as a folded physical array rather than as a flat list of words. The array has 2^(N-K) physical rows. Each row carries 2^K words, so a row is 2^(M+K) bits wide. The upper N-K address bits select a row through a predecoded row decoder that drives one-hot word-lines. The lower K bits select a word slot through a column decoder. On a read that decoder steers a 2^K:1 column multiplexer, and on a write it drives per-column write enables.

Each access takes two phases. In the cycle the request is presented, the row predecoder and the column decoder run side by side while the bit-lines are conditioned, and the decoded selects are captured at the clock edge. In the next cycle exactly one word-line rises and the row is read or written. Inside a row the words are bit-interleaved: bit j of the word in slot c sits at physical column j*2^K + c. Read data is registered at the end of the access phase. Requests may be issued on every cycle, so the decode of one request overlaps the access of the one before it.

Top module: `folded_mem_array`

## Requirements
- R1: After reset, precharge_o is 1, wordline_o is all zero, rd_data is zero, and every word reads back as zero.
- R2: A request presented with acc_en=1 in cycle t makes cycle t+1 an access phase. In that cycle precharge_o is 0 and only bit addr[N-1:K] of wordline_o is set. The row address is predecoded in groups of two bits, and each word-line is the AND of one line from each group.
- R3: A read request (acc_en=1, wr_en=0) in cycle t puts the addressed word on rd_data from cycle t+2. The value holds until the next read completes.
- R4: A write replaces only the word in the addressed column slot (addr[K-1:0]). The other words that share its physical row keep their values.
- R5: A read issued in the cycle right after a write to the same address returns the newly written data.
- R6: In a cycle with acc_en=0, wr_en, addr and wr_data are ignored. The next cycle is a precharge phase with precharge_o=1 and wordline_o all zero, the memory contents are unchanged, and rd_data is unchanged.
- R7: A write access does not change rd_data.
- R8: Over any sequence of accesses, each read returns the value last written to that address, as kept in a flat array of 2^N words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Request strobe for this cycle |
| wr_en | input | 1 | 1 = write request, 0 = read request |
| addr | input | ADDR_BITS | Word address; upper bits select the row, lower FOLD_LOG2 bits select the column slot |
| wr_data | input | 2^WORD_LOG2 | Write data |
| rd_data | output | 2^WORD_LOG2 | Registered read data |
| wordline_o | output | 2^(ADDR_BITS-FOLD_LOG2) | One-hot row word-lines, active in the access phase |
| precharge_o | output | 1 | 1 while the array is in the bit-line conditioning phase |

## Verification
The first pattern fills every address with its own value and reads each one back. A wrong row decode, a wrong column decode or a misrouted interleaved bit gives a wrong read value there. Two words in the same physical row are then written, and one of them is rewritten. This separates a correct per-column write enable from a whole-row write. A write followed at once by a read of the same address tests the overlap of decode and access, while idle cycles with wr_en raised test that a write cannot leak through when acc_en is low. A long random run compares each read with a flat reference array and catches mixing between slots or rows that the directed patterns miss.

// File: rtl/folded_mem_pkg.sv
package folded_mem_pkg;

    // Number of lines produced by one two-bit predecode group.
    localparam int unsigned PDEC_LINES = 4;

    // Number of two-bit predecode groups needed for a row address.
    function automatic int unsigned pdec_groups(input int unsigned row_bits);
        return (row_bits + 1) / 2;
    endfunction

endpackage

// File: rtl/fm_row_predecoder.sv
module fm_row_predecoder
    import folded_mem_pkg::*;
#(
    parameter int unsigned RB = 2,
    localparam int unsigned NGRP = pdec_groups(RB),
    localparam int unsigned LW = NGRP * PDEC_LINES
) (
    input  logic [RB-1:0] row_addr,
    output logic [LW-1:0] grp_lines
);

    // Each pair of address bits becomes a one-hot group of four lines.
    // A trailing single bit uses only two lines of its group.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (2 * g + 1 < RB) begin : g_pair
            assign grp_lines[g*PDEC_LINES +: PDEC_LINES] =
                4'b0001 << row_addr[2*g +: 2];
        end else begin : g_single
            assign grp_lines[g*PDEC_LINES +: PDEC_LINES] =
                {2'b00, row_addr[2*g], ~row_addr[2*g]};
        end
    end

endmodule

// File: rtl/fm_wordline_gen.sv
module fm_wordline_gen
    import folded_mem_pkg::*;
#(
    parameter int unsigned RB = 2,
    localparam int unsigned NGRP = pdec_groups(RB),
    localparam int unsigned LW = NGRP * PDEC_LINES,
    localparam int unsigned ROWS = 1 << RB
) (
    input  logic [LW-1:0]   grp_lines,
    input  logic            enable,
    output logic [ROWS-1:0] wordline
);

    // Each word-line ANDs one line from every group with the phase enable.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_comb begin
            logic acc;
            acc = enable;
            for (int g = 0; g < NGRP; g++) begin
                acc = acc & grp_lines[g*PDEC_LINES + ((r >> (2*g)) % PDEC_LINES)];
            end
            wordline[r] = acc;
        end
    end

endmodule

// File: rtl/fm_col_decoder.sv
module fm_col_decoder #(
    parameter int unsigned K = 1,
    localparam int unsigned COLS = 1 << K
) (
    input  logic [K-1:0]    col_addr,
    output logic [COLS-1:0] col_oh
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_oh[c] = (col_addr == K'(c));
    end

endmodule

// File: rtl/fm_col_mux.sv
module fm_col_mux #(
    parameter int unsigned WORD_W = 4,
    parameter int unsigned COLS = 2,
    localparam int unsigned ROW_W = WORD_W * COLS
) (
    input  logic [ROW_W-1:0]  row_bits,
    input  logic [COLS-1:0]   col_oh,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic [ROW_W-1:0]  wr_row
);

    // Bit j of slot c lives at physical column j*COLS + c.
    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
        assign rd_word[j] = |(row_bits[j*COLS +: COLS] & col_oh);
        for (genvar c = 0; c < COLS; c++) begin : g_slot
            assign wr_row[j*COLS + c] = col_oh[c] ? wdata[j] : row_bits[j*COLS + c];
        end
    end

endmodule

// File: rtl/folded_mem_array.sv
module folded_mem_array
    import folded_mem_pkg::*;
#(
    parameter int unsigned ADDR_BITS = 3,
    parameter int unsigned WORD_LOG2 = 2,
    parameter int unsigned FOLD_LOG2 = 1,
    localparam int unsigned RB = ADDR_BITS - FOLD_LOG2,
    localparam int unsigned ROWS = 1 << RB,
    localparam int unsigned COLS = 1 << FOLD_LOG2,
    localparam int unsigned WORD_W = 1 << WORD_LOG2,
    localparam int unsigned ROW_W = WORD_W * COLS,
    localparam int unsigned NGRP = pdec_groups(RB),
    localparam int unsigned LW = NGRP * PDEC_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic [ROWS-1:0]      wordline_o,
    output logic                 precharge_o
);

    typedef struct packed {
        logic                        vld;
        logic                        we;
        logic [LW-1:0]               grp;
        logic [COLS-1:0]             col;
        logic [WORD_W-1:0]           wd;
        logic [ROWS-1:0][ROW_W-1:0]  mem;
        logic [WORD_W-1:0]           rd;
    } state_t;

    state_t state_d, state_q;

    logic [LW-1:0]     grp_w;
    logic [COLS-1:0]   col_w;
    logic [ROWS-1:0]   wordline;
    logic [ROW_W-1:0]  row_bits;
    logic [WORD_W-1:0] rd_word;
    logic [ROW_W-1:0]  wr_row;

    // Phase 1: row predecode and column decode run side by side.
    fm_row_predecoder #(.RB(RB)) u_pre (
        .row_addr  (addr[ADDR_BITS-1:FOLD_LOG2]),
        .grp_lines (grp_w)
    );

    fm_col_decoder #(.K(FOLD_LOG2)) u_col (
        .col_addr (addr[FOLD_LOG2-1:0]),
        .col_oh   (col_w)
    );

    // Phase 2: registered selects drive one word-line.
    fm_wordline_gen #(.RB(RB)) u_wl (
        .grp_lines (state_q.grp),
        .enable    (state_q.vld),
        .wordline  (wordline)
    );

    // Bit-lines: wired-OR of the rows, only the selected row contributes.
    always_comb begin
        row_bits = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_bits = row_bits | (state_q.mem[r] & {ROW_W{wordline[r]}});
        end
    end

    fm_col_mux #(.WORD_W(WORD_W), .COLS(COLS)) u_mux (
        .row_bits (row_bits),
        .col_oh   (state_q.col),
        .wdata    (state_q.wd),
        .rd_word  (rd_word),
        .wr_row   (wr_row)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = acc_en;
        state_d.we  = acc_en & wr_en;
        if (acc_en) begin
            state_d.grp = grp_w;
            state_d.col = col_w;
            state_d.wd  = wr_data;
        end
        for (int r = 0; r < ROWS; r++) begin
            if (wordline[r] && state_q.we) begin
                state_d.mem[r] = wr_row;
            end
        end
        if (state_q.vld && !state_q.we) begin
            state_d.rd = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data     = state_q.rd;
    assign wordline_o  = wordline;
    assign precharge_o = ~state_q.vld;

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int unsigned ADDR_BITS = 3,
    parameter int unsigned FOLD_LOG2 = 1,
    parameter int unsigned WORD_W = 4,
    localparam int unsigned ROWS = 1 << (ADDR_BITS - FOLD_LOG2)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_en,
    input logic                 wr_en,
    input logic [ADDR_BITS-1:0] addr,
    input logic [WORD_W-1:0]    rd_data,
    input logic [ROWS-1:0]      wordline_o,
    input logic                 precharge_o
);

    // R2: access phase has exactly one word-line
    p_onehot_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !precharge_o |-> $countones(wordline_o) == 1);

    // R2: the selected word-line follows the registered row address
    p_row_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> wordline_o == (ROWS'(1) << $past(addr >> FOLD_LOG2)));

    // R6: no word-line during precharge, and an idle cycle leads to precharge
    p_quiet_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        precharge_o |-> wordline_o == '0);

    p_idle_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> precharge_o);

    // R7: rd_data only moves at the end of a read access
    p_hold_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (precharge_o || $past(wr_en)) |=> $stable(rd_data));

endmodule

bind folded_mem_array fm_checker #(
    .ADDR_BITS (ADDR_BITS),
    .FOLD_LOG2 (FOLD_LOG2),
    .WORD_W    (WORD_W)
) u_fm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en      (acc_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .rd_data     (rd_data),
    .wordline_o  (wordline_o),
    .precharge_o (precharge_o)
);

// File: tb/folded_mem_array_tb.sv
module folded_mem_array_tb;

    localparam int AB    = 3;
    localparam int WL2   = 2;
    localparam int FL2   = 1;
    localparam int WORDS = 1 << AB;
    localparam int ROWS  = 1 << (AB - FL2);
    localparam int WW    = 1 << WL2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [AB-1:0] addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic [ROWS-1:0] wordline_o;
    logic          precharge_o;

    logic [WW-1:0] ref_mem [WORDS];

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    folded_mem_array #(.ADDR_BITS(AB), .WORD_LOG2(WL2), .FOLD_LOG2(FL2)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .wr_en       (wr_en),
        .addr        (addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .wordline_o  (wordline_o),
        .precharge_o (precharge_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s act=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic w, input int a, input int d);
        @(negedge clk);
        acc_en  = e;
        wr_en   = w;
        addr    = AB'(a);
        wr_data = WW'(d);
    endtask

    task automatic set_idle();
        acc_en  = 1'b0;
        wr_en   = 1'b0;
        addr    = '0;
        wr_data = '0;
    endtask

    function automatic int row_oh(input int a);
        return 1 << (a >> FL2);
    endfunction

    // Write: access phase checked one cycle after issue (R2).
    task automatic wr(input int a, input int d);
        drive(1'b1, 1'b1, a, d);
        @(negedge clk);
        chk("R2", "precharge in write access", int'(precharge_o), 0);
        chk("R2", "wordline in write access", int'(wordline_o), row_oh(a));
        set_idle();
        ref_mem[a] = WW'(d);
    endtask

    // Read: data visible two cycles after issue (R3).
    task automatic rd_check(input int a, input string req);
        drive(1'b1, 1'b0, a, 0);
        @(negedge clk);
        chk("R2", "wordline in read access", int'(wordline_o), row_oh(a));
        set_idle();
        @(negedge clk);
        chk(req, $sformatf("rd_data addr %0d", a), int'(rd_data), int'(ref_mem[a]));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "precharge after reset", int'(precharge_o), 1);
        chk("R1", "wordline after reset", int'(wordline_o), 0);
        chk("R1", "rd_data after reset", int'(rd_data), 0);
        for (int a = 0; a < WORDS; a++) rd_check(a, "R1");
    endtask

    task automatic t_fill();
        for (int a = 0; a < WORDS; a++) wr(a, (a * 5 + 3) % 16);
        for (int a = WORDS - 1; a >= 0; a--) rd_check(a, "R3");
    endtask

    task automatic t_shared_row();
        wr(4, 4'hA);
        wr(5, 4'h5);
        rd_check(4, "R4");
        rd_check(5, "R4");
        wr(5, 4'hC);
        rd_check(4, "R4");
        rd_check(5, "R4");
        wr(2, 4'hF);
        wr(3, 4'h0);
        rd_check(2, "R4");
    endtask

    task automatic t_back_to_back();
        drive(1'b1, 1'b1, 6, 4'h9);
        ref_mem[6] = 4'h9;
        @(negedge clk);
        chk("R5", "wordline of write", int'(wordline_o), row_oh(6));
        acc_en = 1'b1; wr_en = 1'b0; addr = 3'd6; wr_data = '0;
        @(negedge clk);
        chk("R5", "wordline of read", int'(wordline_o), row_oh(6));
        set_idle();
        @(negedge clk);
        chk("R5", "read after write", int'(rd_data), 9);
    endtask

    task automatic t_ignored();
        logic [WW-1:0] held;
        rd_check(3, "R6");
        held = rd_data;
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b1, 3, ~ref_mem[3]);
            @(negedge clk);
            chk("R6", "precharge when idle", int'(precharge_o), 1);
            chk("R6", "wordline when idle", int'(wordline_o), 0);
            chk("R6", "rd_data when idle", int'(rd_data), int'(held));
            set_idle();
        end
        rd_check(3, "R6");
    endtask

    task automatic t_write_keeps_rdata();
        rd_check(1, "R7");
        wr(0, ~ref_mem[1]);
        @(negedge clk);
        chk("R7", "rd_data after write", int'(rd_data), int'(ref_mem[1]));
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            int a;
            a = $urandom_range(WORDS - 1, 0);
            if ($urandom_range(1, 0) == 1) wr(a, $urandom_range(15, 0));
            else rd_check(a, "R8");
        end
        for (int a = 0; a < WORDS; a++) rd_check(a, "R8");
    endtask

    initial begin
        for (int a = 0; a < WORDS; a++) ref_mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_shared_row();
        t_back_to_back();
        t_ignored();
        t_write_keeps_rdata();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule